// File: doc/BRIEF.md
# Boot Watchdog and Millisecond Countdown Timer

This block is a countdown timer that runs on the core clock and counts in millisecond units. A programmable prescaler divides the core clock down to a one-cycle millisecond tick. A loadable count register sets how many ticks pass before the timer expires. Right after reset the timer is already running with a four-second load, which makes it a watchdog for the boot-load sequence.

When it expires, the timer raises one of two events. It raises a boot-timeout pulse if the boot flag is high at that moment, and a general timer pulse otherwise. When the boot engine reports completion, the count is forced to zero and the timer disables itself. Software can then reuse the timer as a one-shot or as a free-running periodic source. Each event pulse also sets a sticky status bit, which software clears by writing 1 to it.

The control is a two-state machine. In `ST_IDLE` the count is zero and nothing is counted. In `ST_RUN` the count decrements on each tick. The transitions are as follows:
- IDLE→RUN happens on a nonzero count write.
- RUN→IDLE happens on boot completion, on a zero count write, or on a one-shot expiry.
- RUN→RUN with reload happens on a free-running expiry.
- RUN→RUN with restart happens on a nonzero count write.

Reset enters `ST_RUN`.

Top module: `ms_boot_timer`

## Requirements
- R1: After reset the count reads 4000 (0x0FA0), the timer is running, the free-run bit is 0, the divider holds DIV_RST (default 4), and both pulses and both sticky bits are 0. The first event arrives 4000×DIV_RST cycles after reset is released.
- R2: The prescaler produces one tick every D core cycles, where D is the divider value and a value of 0 acts as 1. The count decrements only on ticks. After a write of COUNT=N, the expiry pulse is visible N×D cycles after the write edge.
- R3: On expiry, the boot-timeout pulse fires if boot_active is 1, and the timer pulse fires otherwise. The two never fire together.
- R4: With free-run set at expiry, the count reloads the last written COUNT value and the timer keeps running. Events then repeat every N×D cycles.
- R5: With free-run clear at expiry, the timer goes idle with a count of 0. It produces no further event until a new nonzero COUNT is written.
- R6: Writing COUNT=0 stops the timer, and no event is produced.
- R7: A COUNT write while the timer is running restarts the countdown from the new value with the prescaler phase cleared. The new value reads back in the cycle after the write.
- R8: A boot_done pulse forces the count to 0 and the timer to idle. If boot_done arrives in the same cycle as an expiry, no event is raised.
- R9: Each event pulse lasts one cycle unless the next expiry follows at once. Each pulse sets its sticky bit. A clear write sets a sticky bit to 0 only where the matching data bit is 1, and a new event in the same cycle wins over the clear.
- R10: Write selects: 0 = COUNT (data[15:0]), 1 = control (data[0] = free-run), 2 = divider (data[15:0]), 3 = sticky clear (data[0] = boot-timeout bit, data[1] = timer bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_active | input | 1 | High while the boot-load sequence runs |
| boot_done | input | 1 | One-cycle boot completion pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | 16 | Write data |
| boot_to_pulse | output | 1 | Boot-timeout event pulse |
| tmr_evt_pulse | output | 1 | General timer event pulse |
| boot_to_sticky | output | 1 | Sticky boot-timeout status |
| tmr_evt_sticky | output | 1 | Sticky timer status |
| cur_count | output | 16 | Current remaining count |
| running | output | 1 | Timer is in the run state |
| freerun_q | output | 1 | Current free-run setting |

## Verification
Some properties are checked by assertions on every cycle:
- The two event pulses are mutually exclusive.
- The idle state always holds a zero count.
- A boot_done pulse always leaves the timer idle and suppresses any event in the next cycle.
- A one-shot expiry always ends in idle.
- The prescaler wraps to zero after every tick.
- Every pulse coincides with its sticky bit.

Other behaviours can only be shown by the bench's scenarios:
- the exact N×D expiry latency across a sweep of counts, divisors and modes;
- the free-run period;
- the restart on an in-flight write;
- the four-second default boot timeout;
- the same-cycle race between boot_done and expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_CLR   = 2'd3
    } wsel_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W   = 16,
    parameter int DIV_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             run,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] last_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RST);
        end else if (div_wr) begin
            div_q <= div_val;
        end
    end

    always_comb begin
        div_eff    = (div_q == '0) ? DIV_W'(1) : div_q;
        last_phase = div_eff - DIV_W'(1);
        tick       = run && !restart && (pre_q >= last_phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || !run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> (pre_q == $past(pre_q) + DIV_W'(1)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CNT_RST = 16'h0FA0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             boot_done,
    input  logic             freerun,
    output logic             expire,
    output logic             run,
    output logic [CNT_W-1:0] cnt_q
);
    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] rld_q, rld_d;

    // State and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= CNT_W'(CNT_RST);
            rld_q <= CNT_W'(CNT_RST);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rld_q <= rld_d;
        end
    end

    // Next state and expiry output
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        rld_d  = cnt_wr ? cnt_val : rld_q;
        expire = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (boot_done) begin
                    cnt_d = '0;
                end else if (cnt_wr && (cnt_val != '0)) begin
                    st_d  = ST_RUN;
                    cnt_d = cnt_val;
                end
            end
            ST_RUN: begin
                if (boot_done) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else if (cnt_wr) begin
                    cnt_d = cnt_val;
                    st_d  = (cnt_val == '0) ? ST_IDLE : ST_RUN;
                end else if (tick) begin
                    if (cnt_q <= CNT_W'(1)) begin
                        expire = 1'b1;
                        if (freerun && (rld_q != '0)) begin
                            cnt_d = rld_q;
                        end else begin
                            st_d  = ST_IDLE;
                            cnt_d = '0;
                        end
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    assign run = (st_q == ST_RUN);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (cnt_q == '0));

    // R8
    boot_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> (st_q == ST_IDLE) && (cnt_q == '0));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !freerun) |=> (st_q == ST_IDLE));

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr && !boot_done) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_events.sv
module tmr_events (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       boot_active,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    output logic       boot_to_pulse,
    output logic       tmr_evt_pulse,
    output logic       boot_to_sticky,
    output logic       tmr_evt_sticky
);
    logic hit_boot;
    logic hit_tmr;

    always_comb begin
        hit_boot = expire && boot_active;
        hit_tmr  = expire && !boot_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_to_pulse  <= 1'b0;
            tmr_evt_pulse  <= 1'b0;
            boot_to_sticky <= 1'b0;
            tmr_evt_sticky <= 1'b0;
        end else begin
            boot_to_pulse  <= hit_boot;
            tmr_evt_pulse  <= hit_tmr;
            boot_to_sticky <= hit_boot || (boot_to_sticky && !(clr_wr && clr_bits[0]));
            tmr_evt_sticky <= hit_tmr  || (tmr_evt_sticky && !(clr_wr && clr_bits[1]));
        end
    end

    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_to_pulse, tmr_evt_pulse}));

    // R9
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_to_pulse |-> boot_to_sticky);

    // R9
    tmr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt_pulse |-> tmr_evt_sticky);

endmodule

// File: rtl/ms_boot_timer.sv
module ms_boot_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int DIV_W   = 16,
    parameter int CNT_RST = 16'h0FA0,
    parameter int DIV_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_active,
    input  logic              boot_done,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              boot_to_pulse,
    output logic              tmr_evt_pulse,
    output logic              boot_to_sticky,
    output logic              tmr_evt_sticky,
    output logic [CNT_W-1:0]  cur_count,
    output logic              running,
    output logic              freerun_q
);
    logic cnt_wr, ctrl_wr, div_wr, clr_wr;
    logic tick, expire;

    always_comb begin
        cnt_wr  = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
        ctrl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
        div_wr  = wr_en && (wsel_e'(wr_sel) == SEL_DIV);
        clr_wr  = wr_en && (wsel_e'(wr_sel) == SEL_CLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freerun_q <= 1'b0;
        end else if (ctrl_wr) begin
            freerun_q <= wr_data[0];
        end
    end

    tmr_prescaler #(
        .DIV_W  (DIV_W),
        .DIV_RST(DIV_RST)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_wr (div_wr),
        .div_val(wr_data[DIV_W-1:0]),
        .run    (running),
        .restart(cnt_wr),
        .tick   (tick)
    );

    tmr_core #(
        .CNT_W  (CNT_W),
        .CNT_RST(CNT_RST)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .cnt_val  (wr_data[CNT_W-1:0]),
        .boot_done(boot_done),
        .freerun  (freerun_q),
        .expire   (expire),
        .run      (running),
        .cnt_q    (cur_count)
    );

    tmr_events u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .expire        (expire),
        .boot_active   (boot_active),
        .clr_wr        (clr_wr),
        .clr_bits      (wr_data[1:0]),
        .boot_to_pulse (boot_to_pulse),
        .tmr_evt_pulse (tmr_evt_pulse),
        .boot_to_sticky(boot_to_sticky),
        .tmr_evt_sticky(tmr_evt_sticky)
    );

    // R8
    boot_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> !boot_to_pulse && !tmr_evt_pulse);

    // R6
    zero_write_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && (wr_data[CNT_W-1:0] == '0) && !boot_done) |=> !running);

endmodule

// File: tb/tb_ms_boot_timer.sv
`timescale 1ns/1ps
module tb_ms_boot_timer;
    localparam int DRST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_active = 1'b0;
    logic        boot_done = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        boot_to_pulse, tmr_evt_pulse, boot_to_sticky, tmr_evt_sticky;
    logic [15:0] cur_count;
    logic        running, freerun_q;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ms_boot_timer #(.DIV_RST(DRST)) dut (
        .clk(clk), .rst_n(rst_n), .boot_active(boot_active), .boot_done(boot_done),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .boot_to_pulse(boot_to_pulse), .tmr_evt_pulse(tmr_evt_pulse),
        .boot_to_sticky(boot_to_sticky), .tmr_evt_sticky(tmr_evt_sticky),
        .cur_count(cur_count), .running(running), .freerun_q(freerun_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // k = 1 at the negedge right after the write edge
    task automatic wait_evt(output int k, input int lim);
        k = 1;
        while (!(boot_to_pulse || tmr_evt_pulse) && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (boot_to_pulse || tmr_evt_pulse) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int k;
        int j;
        do_reset();
        boot_active = 1'b1;
        // R1: reset state
        chk(cur_count == 16'h0FA0, "R1 count", cur_count, 4000);
        chk(running == 1'b1, "R1 running", running, 1);
        chk(freerun_q == 1'b0, "R1 freerun", freerun_q, 0);
        chk(!boot_to_pulse && !tmr_evt_pulse && !boot_to_sticky && !tmr_evt_sticky,
            "R1 events", boot_to_sticky, 0);
        // R1: default boot timeout 4000 ms at DIV_RST cycles per ms
        k = 0;
        while (!(boot_to_pulse || tmr_evt_pulse) && k < 4000 * DRST + 50) begin
            @(negedge clk);
            k++;
        end
        chk(k == 4000 * DRST, "R1 boot timeout latency", k, 4000 * DRST);
        chk(boot_to_pulse && !tmr_evt_pulse, "R3 boot steering", boot_to_pulse, 1);
        chk(boot_to_sticky && !tmr_evt_sticky, "R9 boot sticky", boot_to_sticky, 1);
        @(negedge clk);
        chk(!boot_to_pulse, "R9 single cycle", boot_to_pulse, 0);
        chk(!running && cur_count == 0, "R5 idle after oneshot", cur_count, 0);
        // R9: clear with other bit leaves it, then clear it
        wr(2'd3, 16'h0002);
        chk(boot_to_sticky == 1'b1, "R9 clear ignored", boot_to_sticky, 1);
        wr(2'd3, 16'h0001);
        chk(boot_to_sticky == 1'b0, "R9 clear", boot_to_sticky, 0);

        // R8: boot_done disables the boot watchdog
        do_reset();
        repeat (10) @(negedge clk);
        boot_done = 1'b1;
        @(negedge clk);
        boot_done = 1'b0;
        chk(cur_count == 0 && !running, "R8 boot done", cur_count, 0);
        quiet(4000 * DRST + 50, "R8 no timeout after done");
        chk(!boot_to_sticky, "R8 sticky clear", boot_to_sticky, 0);

        // R8: boot_done in the expiry cycle
        wr(2'd2, 16'd1);
        wr(2'd0, 16'd3);
        @(negedge clk);
        @(negedge clk);
        boot_done = 1'b1;
        @(negedge clk);
        boot_done = 1'b0;
        chk(!boot_to_pulse && !tmr_evt_pulse, "R8 race no event", boot_to_pulse, 0);
        chk(cur_count == 0 && !running, "R8 race idle", cur_count, 0);
        quiet(10, "R8 race quiet");
        chk(!boot_to_sticky && !tmr_evt_sticky, "R8 race sticky", boot_to_sticky, 0);

        // R3: boot-active expiry from a software load
        wr(2'd0, 16'd2);
        wait_evt(k, 30);
        chk(k == 3, "R3 latency", k, 3);
        chk(boot_to_pulse && !tmr_evt_pulse, "R3 boot pulse", tmr_evt_pulse, 0);
        wr(2'd3, 16'h0003);
        boot_active = 1'b0;

        // R2 R4 R5: sweep over divider, count and mode
        for (int fr = 0; fr < 2; fr++) begin
            for (int d = 1; d <= 3; d++) begin
                for (int n = 1; n <= 4; n++) begin
                    wr(2'd1, 16'(fr));
                    wr(2'd2, 16'(d));
                    wr(2'd0, 16'(n));
                    chk(cur_count == 16'(n), "R10 count readback", cur_count, n);
                    wait_evt(k, n * d + 20);
                    chk(k == n * d + 1, "R2 expiry latency", k, n * d + 1);
                    chk(tmr_evt_pulse && !boot_to_pulse, "R3 timer steering", tmr_evt_pulse, 1);
                    if (fr == 1) begin
                        @(negedge clk);
                        j = 1;
                        while (!tmr_evt_pulse && j < n * d + 20) begin
                            @(negedge clk);
                            j++;
                        end
                        chk(j == n * d, "R4 freerun period", j, n * d);
                        chk(running, "R4 still running", running, 1);
                        wr(2'd0, 16'd0);
                        chk(!running && cur_count == 0, "R6 stop", cur_count, 0);
                    end else begin
                        @(negedge clk);
                        chk(!tmr_evt_pulse, "R9 single cycle", tmr_evt_pulse, 0);
                        chk(!running && cur_count == 0, "R5 oneshot idle", cur_count, 0);
                        quiet(3 * n * d + 5, "R5 no repeat");
                    end
                    wr(2'd3, 16'h0003);
                    chk(!tmr_evt_sticky, "R9 clear timer", tmr_evt_sticky, 0);
                end
            end
        end
        wr(2'd1, 16'd0);

        // R2: divider zero acts as one
        wr(2'd2, 16'd0);
        wr(2'd0, 16'd3);
        wait_evt(k, 30);
        chk(k == 4, "R2 divider zero", k, 4);

        // R7: restart while running
        wr(2'd2, 16'd2);
        wr(2'd0, 16'd5);
        repeat (3) @(negedge clk);
        wr(2'd0, 16'd3);
        chk(cur_count == 3, "R7 new value", cur_count, 3);
        wait_evt(k, 40);
        chk(k == 7, "R7 restart latency", k, 7);

        // R6: zero write disables
        wr(2'd0, 16'd4);
        wr(2'd0, 16'd0);
        chk(!running, "R6 zero stops", running, 0);
        quiet(40, "R6 no event");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule